// File: doc/BRIEF.md
# Peripheral I/O Slave for an 8/16-bit Stacked-Card Bus

This block sits on a peripheral card and answers I/O-space cycles on an 8/16-bit parallel expansion bus. It keeps the upper address group captured while the address latch enable is high. It compares the 16 low address bits against a fixed window set by parameters. A matching cycle is served from a small register file: a read drives the data bus and a write samples it. The host's active-low read and write strobes start each cycle.

The block signals a 16-bit-capable target on an active-low select output. That output is decoded from the address alone, so the host can size the cycle before it issues a strobe. Each served cycle is stretched by pulling the ready line low for a whole number of bus clocks. The default is one clock for 16-bit targets and four clocks for 8-bit ones. A back-end busy input can lengthen the stretch further, but a watchdog always frees ready before the bus time limit. A high DMA address-enable masks the block completely.

Top module: `isa_io_slave`

## Requirements
- R1: After reset, io_ready is 1, data_oe is 0, cs16_n is 1, and every register reads back as 0.
- R2: While addr_en is 1, the block ignores both strobes. io_ready stays 1, data_oe stays 0, cs16_n stays 1, and no register is written.
- R3: In the 16-bit variant (WIDE16=1), cs16_n is 0 exactly when addr_en is 0, the captured upper group is zero and addr[15:WIN_BITS] equals BASE_ADDR[15:WIN_BITS]. It depends on no strobe. In the 8-bit variant, cs16_n stays 1.
- R4: la_hi is captured on each clock edge at which ale is 1 and is held while ale is 0. A nonzero captured value blocks every decode.
- R5: When a read (ior_n=0, iow_n=1) hits the window, data_oe rises one clock after the strobe is sampled. While data_oe is 1, data_out carries register addr[WIN_BITS-1:1].
- R6: When a write (iow_n=0, ior_n=1) hits the window, data_in is stored into register addr[WIN_BITS-1:1] on the clock edge that ends the wait. A later read returns the stored value.
- R7: io_ready drops one clock after a matching strobe is sampled. With ext_busy at 0, it stays low for WAIT16 clocks (16-bit variant) or WAIT8 clocks (8-bit variant).
- R8: While ext_busy is 1, io_ready stays low beyond the base count. It returns high after MAX_LOW low clocks at most.
- R9: data_oe returns to 0 on the first clock edge that samples ior_n high.
- R10: An access whose address lies outside the window leaves io_ready at 1, data_oe at 0 and cs16_n at 1, and writes no register.
- R11: In the 8-bit variant, addr[0] picks the byte lane: 0 is bits 7:0 of the register and 1 is bits 15:8. A write stores data_in[7:0] into that lane. A read returns the lane on data_out[7:0], with data_out[15:8] at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_en | input | 1 | DMA address enable; 1 masks the block |
| ale | input | 1 | Address latch enable for the upper group |
| la_hi | input | LA_W | Upper address group |
| addr | input | 16 | Low I/O address bits |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| data_in | input | 16 | Data bus as driven by the host |
| ext_busy | input | 1 | Back-end request for extra wait clocks |
| data_out | output | 16 | Read data toward the bus |
| data_oe | output | 1 | Output enable for data_out |
| cs16_n | output | 1 | Active-low 16-bit target select |
| io_ready | output | 1 | Channel ready; 0 inserts wait states |

## Verification
The assertions assume that the host never drops both strobes at once. They also assume that the address stays steady from the latch-enable phase until the strobe rises, and that write data is steady while the write strobe is low. Under those assumptions, a low ready always traces back to a strobe sampled on the edge before it. Every bench cycle follows that discipline: an address phase with ale high, then a single strobe held until ready has returned high, then a strobe release with the address still in place. The two bench instances sit at different bases, so only one of them ever answers a cycle.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;

    localparam int ISA_AW = 16;
    localparam int ISA_DW = 16;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_WAIT = 2'd1,
        CYC_HOLD = 2'd2
    } cyc_state_e;

endpackage

// File: rtl/isa_io_decode.sv
module isa_io_decode
    import isa_io_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h0300,
    parameter int          WIN_BITS  = 3,
    parameter int          LA_W      = 7,
    parameter bit          WIDE16    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_en,
    input  logic              ale,
    input  logic [LA_W-1:0]   la_hi,
    input  logic [ISA_AW-1:0] addr,
    output logic              match,
    output logic              cs16_n
);

    localparam int TAG_W = ISA_AW - WIN_BITS;

    typedef struct packed {
        logic [LA_W-1:0] upper;
    } dec_t;

    dec_t dec_d, dec_q;

    // Upper group follows the bus while the latch enable is high, holds otherwise.
    always_comb begin
        dec_d = dec_q;
        if (ale) begin
            dec_d.upper = la_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    logic [TAG_W-1:0] tag_bus;
    logic [TAG_W-1:0] tag_base;
    logic             unused_low;

    assign tag_bus    = addr[ISA_AW-1:WIN_BITS];
    assign tag_base   = BASE_ADDR[ISA_AW-1:WIN_BITS];
    assign unused_low = ^addr[WIN_BITS-1:0];

    assign match = !addr_en && (dec_q.upper == '0) && (tag_bus == tag_base);

    generate
        if (WIDE16) begin : g_sel16
            assign cs16_n = !match;
        end else begin : g_sel8
            assign cs16_n = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/isa_io_cycle_fsm.sv
module isa_io_cycle_fsm
    import isa_io_pkg::*;
#(
    parameter int WIN_BITS = 3,
    parameter int BASE_WAIT = 1,
    parameter int MAX_LOW  = 232
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_en,
    input  logic                match,
    input  logic                ior_n,
    input  logic                iow_n,
    input  logic                ext_busy,
    input  logic [WIN_BITS-1:0] addr_lo,
    output logic                io_ready,
    output logic                data_oe,
    output logic                wr_en,
    output logic [WIN_BITS-2:0] sel_idx,
    output logic                sel_lane
);

    localparam int IW    = WIN_BITS - 1;
    localparam int CW    = $clog2(MAX_LOW + 1) + 1;
    localparam int LIMIT = (MAX_LOW < 1) ? 1 : MAX_LOW;
    localparam int BASE  = (BASE_WAIT < 1) ? 1 :
                           ((BASE_WAIT > LIMIT) ? LIMIT : BASE_WAIT);

    typedef struct packed {
        cyc_state_e    st;
        logic [CW-1:0] lowcnt;
        logic          rdy;
        logic          oe;
        logic          is_wr;
        logic [IW-1:0] idx;
        logic          lane;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic rd_low;
    logic wr_low;
    logic active;
    logic release_now;

    assign rd_low = !ior_n;
    assign wr_low = !iow_n;

    // A started cycle stays alive while its own strobe is low and no DMA cycle masks it.
    assign active = !addr_en && (fsm_q.is_wr ? wr_low : rd_low);

    // Base count met with an idle back end, or the hold limit reached regardless.
    assign release_now = ((fsm_q.lowcnt >= CW'(BASE)) && !ext_busy) ||
                         (fsm_q.lowcnt >= CW'(LIMIT));

    always_comb begin
        fsm_d = fsm_q;
        wr_en = 1'b0;
        unique case (fsm_q.st)
            CYC_IDLE: begin
                fsm_d.rdy = 1'b1;
                fsm_d.oe  = 1'b0;
                if (!addr_en && match && (rd_low ^ wr_low)) begin
                    fsm_d.st     = CYC_WAIT;
                    fsm_d.rdy    = 1'b0;
                    fsm_d.lowcnt = CW'(1);
                    fsm_d.is_wr  = wr_low;
                    fsm_d.oe     = rd_low;
                    fsm_d.idx    = addr_lo[WIN_BITS-1:1];
                    fsm_d.lane   = addr_lo[0];
                end
            end
            CYC_WAIT: begin
                if (!active) begin
                    fsm_d.st  = CYC_IDLE;
                    fsm_d.rdy = 1'b1;
                    fsm_d.oe  = 1'b0;
                end else if (release_now) begin
                    fsm_d.st  = CYC_HOLD;
                    fsm_d.rdy = 1'b1;
                    wr_en     = fsm_q.is_wr;
                end else begin
                    fsm_d.lowcnt = fsm_q.lowcnt + CW'(1);
                end
            end
            CYC_HOLD: begin
                fsm_d.rdy = 1'b1;
                if (!active) begin
                    fsm_d.st = CYC_IDLE;
                    fsm_d.oe = 1'b0;
                end
            end
            default: begin
                fsm_d.st  = CYC_IDLE;
                fsm_d.rdy = 1'b1;
                fsm_d.oe  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q        <= '0;
            fsm_q.st     <= CYC_IDLE;
            fsm_q.rdy    <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign io_ready = fsm_q.rdy;
    assign data_oe  = fsm_q.oe;
    assign sel_idx  = fsm_q.idx;
    assign sel_lane = fsm_q.lane;

endmodule

// File: rtl/isa_io_regfile.sv
module isa_io_regfile
    import isa_io_pkg::*;
#(
    parameter int WIN_BITS = 3,
    parameter bit WIDE16   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WIN_BITS-2:0] sel_idx,
    input  logic                sel_lane,
    input  logic [ISA_DW-1:0]   wr_data,
    output logic [ISA_DW-1:0]   rd_data
);

    localparam int NREG = 2 ** (WIN_BITS - 1);

    logic [ISA_DW-1:0] regs_d [NREG];
    logic [ISA_DW-1:0] regs_q [NREG];
    logic [ISA_DW-1:0] word_sel;

    assign word_sel = regs_q[sel_idx];

    generate
        if (WIDE16) begin : g_word
            always_comb begin
                for (int i = 0; i < NREG; i++) begin
                    regs_d[i] = regs_q[i];
                end
                if (wr_en) begin
                    regs_d[sel_idx] = wr_data;
                end
            end

            logic unused_lane;
            assign unused_lane = sel_lane;
            assign rd_data     = word_sel;
        end else begin : g_byte
            always_comb begin
                for (int i = 0; i < NREG; i++) begin
                    regs_d[i] = regs_q[i];
                end
                if (wr_en) begin
                    if (sel_lane) begin
                        regs_d[sel_idx][15:8] = wr_data[7:0];
                    end else begin
                        regs_d[sel_idx][7:0]  = wr_data[7:0];
                    end
                end
            end

            logic unused_hi;
            assign unused_hi = ^wr_data[15:8];
            assign rd_data   = {8'h00, sel_lane ? word_sel[15:8] : word_sel[7:0]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave
    import isa_io_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h0300,
    parameter int          WIN_BITS  = 3,
    parameter int          LA_W      = 7,
    parameter bit          WIDE16    = 1'b1,
    parameter int          WAIT16    = 1,
    parameter int          WAIT8     = 4,
    parameter int          MAX_LOW   = 232
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_en,
    input  logic             ale,
    input  logic [LA_W-1:0]  la_hi,
    input  logic [15:0]      addr,
    input  logic             ior_n,
    input  logic             iow_n,
    input  logic [15:0]      data_in,
    input  logic             ext_busy,
    output logic [15:0]      data_out,
    output logic             data_oe,
    output logic             cs16_n,
    output logic             io_ready
);

    localparam int BASE_WAIT = WIDE16 ? WAIT16 : WAIT8;

    logic                match;
    logic                wr_en;
    logic [WIN_BITS-2:0] sel_idx;
    logic                sel_lane;
    logic [ISA_DW-1:0]   rd_data;

    isa_io_decode #(
        .BASE_ADDR (BASE_ADDR),
        .WIN_BITS  (WIN_BITS),
        .LA_W      (LA_W),
        .WIDE16    (WIDE16)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_en (addr_en),
        .ale     (ale),
        .la_hi   (la_hi),
        .addr    (addr),
        .match   (match),
        .cs16_n  (cs16_n)
    );

    isa_io_cycle_fsm #(
        .WIN_BITS  (WIN_BITS),
        .BASE_WAIT (BASE_WAIT),
        .MAX_LOW   (MAX_LOW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_en  (addr_en),
        .match    (match),
        .ior_n    (ior_n),
        .iow_n    (iow_n),
        .ext_busy (ext_busy),
        .addr_lo  (addr[WIN_BITS-1:0]),
        .io_ready (io_ready),
        .data_oe  (data_oe),
        .wr_en    (wr_en),
        .sel_idx  (sel_idx),
        .sel_lane (sel_lane)
    );

    isa_io_regfile #(
        .WIN_BITS (WIN_BITS),
        .WIDE16   (WIDE16)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel_idx  (sel_idx),
        .sel_lane (sel_lane),
        .wr_data  (data_in),
        .rd_data  (rd_data)
    );

    assign data_out = data_oe ? rd_data : '0;

endmodule

// File: rtl/isa_io_slave_chk.sv
module isa_io_slave_chk #(
    parameter int MAX_LOW = 232
) (
    input logic clk,
    input logic rst_n,
    input logic addr_en,
    input logic ior_n,
    input logic iow_n,
    input logic io_ready,
    input logic data_oe,
    input logic cs16_n
);

    localparam int RW = $clog2(MAX_LOW + 2) + 1;

    logic [RW-1:0] low_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (!io_ready) begin
            low_run_q <= low_run_q + RW'(1);
        end else begin
            low_run_q <= '0;
        end
    end

    // R2
    dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en |=> (!data_oe && io_ready));

    // R2
    dma_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en |-> cs16_n);

    // R9
    oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ior_n |=> !data_oe);

    // R7
    ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_ready |-> $past(!ior_n || !iow_n));

    // R8
    ready_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= RW'(MAX_LOW));

endmodule

bind isa_io_slave isa_io_slave_chk #(.MAX_LOW(MAX_LOW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_en  (addr_en),
    .ior_n    (ior_n),
    .iow_n    (iow_n),
    .io_ready (io_ready),
    .data_oe  (data_oe),
    .cs16_n   (cs16_n)
);

// File: tb/isa_io_slave_bench.sv
`timescale 1ns/1ps
module isa_io_slave_bench;

    localparam int MAXL  = 232;
    localparam int LIM   = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_en = 1'b0;
    logic        ale = 1'b0;
    logic [6:0]  la_hi = '0;
    logic [15:0] addr = '0;
    logic        ior_n = 1'b1;
    logic        iow_n = 1'b1;
    logic [15:0] data_in = '0;
    logic        ext_busy = 1'b0;

    logic [15:0] do16, do8;
    logic        oe16, oe8, cs16, cs8, rdy16, rdy8;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    isa_io_slave #(.BASE_ADDR(16'h0300), .WIDE16(1'b1), .MAX_LOW(MAXL)) u_isa_io_slave (
        .clk(clk), .rst_n(rst_n), .addr_en(addr_en), .ale(ale), .la_hi(la_hi),
        .addr(addr), .ior_n(ior_n), .iow_n(iow_n), .data_in(data_in),
        .ext_busy(ext_busy), .data_out(do16), .data_oe(oe16), .cs16_n(cs16),
        .io_ready(rdy16)
    );

    isa_io_slave #(.BASE_ADDR(16'h0310), .WIDE16(1'b0), .MAX_LOW(MAXL)) u_isa_io_slave_b8 (
        .clk(clk), .rst_n(rst_n), .addr_en(addr_en), .ale(ale), .la_hi(la_hi),
        .addr(addr), .ior_n(ior_n), .iow_n(iow_n), .data_in(data_in),
        .ext_busy(ext_busy), .data_out(do8), .data_oe(oe8), .cs16_n(cs8),
        .io_ready(rdy8)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One bus cycle: address phase, one strobe until ready returns, strobe release.
    task automatic bus_cycle(input bit b8, input logic [15:0] a, input logic [6:0] up,
                             input bit aen, input bit wr, input logic [15:0] wd,
                             input bit busy, input int limit,
                             output int lowcnt, output logic [15:0] rd,
                             output bit saw_oe, output bit cs_low, output bit oe_after);
        @(negedge clk);
        addr = a; la_hi = up; ale = 1'b1; addr_en = aen;
        ior_n = 1'b1; iow_n = 1'b1; data_in = wd; ext_busy = busy;
        @(negedge clk);
        cs_low = b8 ? !cs8 : !cs16;
        ale = 1'b0;
        if (wr) iow_n = 1'b0; else ior_n = 1'b0;
        lowcnt = 0; saw_oe = 1'b0; rd = '0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (b8 ? oe8 : oe16) saw_oe = 1'b1;
            if (!(b8 ? rdy8 : rdy16)) lowcnt++;
            else if (lowcnt > 0) begin
                rd = b8 ? do8 : do16;
                break;
            end
        end
        ior_n = 1'b1; iow_n = 1'b1;
        @(negedge clk);
        oe_after = b8 ? oe8 : oe16;
        addr_en = 1'b0; ext_busy = 1'b0;
    endtask

    task automatic do_write(input bit b8, input logic [15:0] a, input logic [15:0] wd,
                            input string req, input int exp_low);
        int lc; logic [15:0] rd; bit so, cl, oa;
        bus_cycle(b8, a, 7'h0, 1'b0, 1'b1, wd, 1'b0, 20, lc, rd, so, cl, oa);
        check(lc == exp_low, req, "write wait clocks", lc, exp_low);
    endtask

    task automatic do_read(input bit b8, input logic [15:0] a, input logic [15:0] exp,
                           input string req);
        int lc; logic [15:0] rd; bit so, cl, oa;
        bus_cycle(b8, a, 7'h0, 1'b0, 1'b0, 16'h0, 1'b0, 20, lc, rd, so, cl, oa);
        check(rd == exp, req, "read data", rd, exp);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(rdy16 && rdy8, "R1", "ready after reset", {rdy16, rdy8}, 3);
        check(!oe16 && !oe8, "R1", "oe after reset", {oe16, oe8}, 0);
        check(cs16 && cs8, "R1", "cs16_n after reset", {cs16, cs8}, 3);
        do_read(1'b0, 16'h0306, 16'h0000, "R1");
        do_read(1'b1, 16'h0311, 16'h0000, "R1");
    endtask

    task automatic test_rw16();
        int lc; logic [15:0] rd; bit so, cl, oa;
        do_write(1'b0, 16'h0302, 16'hBEEF, "R6", 1);
        do_write(1'b0, 16'h0304, 16'h1234, "R6", 1);
        bus_cycle(1'b0, 16'h0302, 7'h0, 1'b0, 1'b0, 16'h0, 1'b0, 20, lc, rd, so, cl, oa);
        check(rd == 16'hBEEF, "R5", "read reg1", rd, 16'hBEEF);
        check(so, "R5", "oe seen during read", so, 1);
        check(lc == 1, "R7", "16-bit wait clocks", lc, 1);
        check(cl, "R3", "cs16_n low in window", cl, 1);
        check(!oa, "R9", "oe after strobe rise", oa, 0);
        do_read(1'b0, 16'h0304, 16'h1234, "R6");
        do_read(1'b0, 16'h0300, 16'h0000, "R5");
    endtask

    task automatic test_dma();
        int lc; logic [15:0] rd; bit so, cl, oa;
        bus_cycle(1'b0, 16'h0302, 7'h0, 1'b1, 1'b1, 16'h1111, 1'b0, 10, lc, rd, so, cl, oa);
        check(lc == 0, "R2", "ready under DMA write", lc, 0);
        check(!cl, "R2", "cs16_n under DMA", cl, 0);
        bus_cycle(1'b0, 16'h0302, 7'h0, 1'b1, 1'b0, 16'h0, 1'b0, 10, lc, rd, so, cl, oa);
        check(!so, "R2", "oe under DMA read", so, 0);
        check(lc == 0, "R2", "ready under DMA read", lc, 0);
        do_read(1'b0, 16'h0302, 16'hBEEF, "R2");
    endtask

    task automatic test_window();
        int lc; logic [15:0] rd; bit so, cl, oa;
        bus_cycle(1'b0, 16'h0308, 7'h0, 1'b0, 1'b1, 16'h7777, 1'b0, 10, lc, rd, so, cl, oa);
        check(lc == 0 && !cl, "R10", "outside write response", {lc[7:0], cl}, 0);
        bus_cycle(1'b0, 16'h0702, 7'h0, 1'b0, 1'b1, 16'h7777, 1'b0, 10, lc, rd, so, cl, oa);
        check(lc == 0 && !cl, "R10", "alias write response", {lc[7:0], cl}, 0);
        bus_cycle(1'b0, 16'h02FE, 7'h0, 1'b0, 1'b0, 16'h0, 1'b0, 10, lc, rd, so, cl, oa);
        check(!so && lc == 0, "R10", "outside read response", {lc[7:0], so}, 0);
        do_read(1'b0, 16'h0302, 16'hBEEF, "R10");
    endtask

    task automatic test_upper();
        int lc; logic [15:0] rd; bit so, cl, oa;
        bus_cycle(1'b0, 16'h0302, 7'h01, 1'b0, 1'b1, 16'h2222, 1'b0, 10, lc, rd, so, cl, oa);
        check(lc == 0, "R4", "nonzero upper blocks write", lc, 0);
        check(!cl, "R4", "nonzero upper blocks cs16", cl, 0);
        // Upper group back to zero: captured again while ale is high.
        do_read(1'b0, 16'h0302, 16'hBEEF, "R4");
    endtask

    task automatic test_bytes8();
        int lc; logic [15:0] rd; bit so, cl, oa;
        do_write(1'b1, 16'h0313, 16'hAA5A, "R11", 4);
        do_write(1'b1, 16'h0312, 16'hBB3C, "R7", 4);
        bus_cycle(1'b1, 16'h0313, 7'h0, 1'b0, 1'b0, 16'h0, 1'b0, 20, lc, rd, so, cl, oa);
        check(rd == 16'h005A, "R11", "high lane read", rd, 16'h005A);
        check(lc == 4, "R7", "8-bit wait clocks", lc, 4);
        check(!cl, "R3", "8-bit variant cs16_n", cl, 0);
        do_read(1'b1, 16'h0312, 16'h003C, "R11");
        do_read(1'b1, 16'h0316, 16'h0000, "R11");
    endtask

    task automatic test_watchdog();
        int lc; logic [15:0] rd; bit so, cl, oa;
        bus_cycle(1'b0, 16'h0304, 7'h0, 1'b0, 1'b0, 16'h0, 1'b1, LIM, lc, rd, so, cl, oa);
        check(lc == MAXL, "R8", "busy ready hold", lc, MAXL);
        check(rd == 16'h1234, "R8", "read after watchdog", rd, 16'h1234);
        bus_cycle(1'b1, 16'h0310, 7'h0, 1'b0, 1'b1, 16'h0099, 1'b1, LIM, lc, rd, so, cl, oa);
        check(lc == MAXL, "R8", "8-bit busy hold", lc, MAXL);
        do_read(1'b1, 16'h0310, 16'h0099, "R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_rw16();
        test_dma();
        test_window();
        test_upper();
        test_bytes8();
        test_watchdog();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule